// File: doc/BRIEF.md
# I2C Master Register and Interrupt Interface

This block is the register file that sits between a system bus and the byte-level sequencer of an I2C master. A host reaches it through an 8-bit WISHBONE Classic slave port with a 3-bit address. Through that port the host sets up a 16-bit clock divider, an enable and an interrupt enable, and a byte to send. It can also issue commands and read back the received byte and the transfer status. Each bus access takes two clock cycles. Acknowledge and read data are registered and appear together in the second cycle.

Commands written by the host reach the byte sequencer as single-cycle pulses: start, stop, read and write. The block also passes on an ACK/NACK level for the receive acknowledge. It takes completion, arbitration-lost, acknowledge and bus-busy indications back from the sequencer. It keeps a sticky interrupt flag and drives an interrupt line. The divider value is the system clock divided by five times the SCL rate, minus one. For example, a 32 MHz clock and 100 kHz SCL give 63. Commands are accepted only while the enable bit is set. Clearing the enable bit cancels any read or write that is still pending.

Top module: `i2c_regif`

## Requirements
- R1: After reset the divider output is 0xFFFF. Enable, interrupt enable, transmit data and the received byte are all 0x00. The status byte reads 0x00, and `irq_o` and `wb_ack` are low.
- R2: `wb_ack` is high for exactly one cycle: the cycle after the first clock edge at which `wb_cyc` and `wb_stb` are both high. Read data is valid in that same cycle, and a held strobe produces no second write.
- R3: The address map is: 0 = divider bits 7:0, 1 = divider bits 15:8, 2 = control (bit 7 enable, bit 6 interrupt enable, bits 5:0 read as zero), 3 = transmit byte on write and received byte on read, 4 = command on write and status on read. Other addresses read as 0x00.
- R4: A write to address 4 while enabled produces one-cycle pulses in the cycle after the write edge: bit 7 gives start, bit 6 stop, bit 5 read and bit 4 write. Bit 3 is held on `cmd_nack_o` (1 = NACK).
- R5: A command write while enable is 0 produces no pulse and sets no transfer in progress.
- R6: Status bit 1 (transfer in progress) is set by an accepted read or write command. It clears when `ctl_done_i` or `ctl_al_i` is seen.
- R7: Status bit 0 (interrupt flag) is set by `ctl_done_i` or `ctl_al_i`. It stays set until a command write with bit 0 = 1; if both happen at the same edge, the set wins.
- R8: `irq_o` equals the interrupt flag AND interrupt enable, delayed by one cycle.
- R9: On `ctl_done_i` the block latches `rx_data_i` as the received byte and `ctl_rxack_i` as status bit 7. Status bit 6 shows `ctl_busy_i`. Status bit 5 is a sticky arbitration-lost flag, set by `ctl_al_i` and cleared by an accepted start command.
- R10: One cycle after enable is 0, transfer in progress is 0.
- R11: The asynchronous reset (active level set by `ARST_ACTIVE`, default low) acts at once without a clock edge. The synchronous active-high `srst` gives the same reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| arst | input | 1 | Asynchronous reset, level set by ARST_ACTIVE |
| wb_adr | input | 3 | Register address |
| wb_wdat | input | 8 | Write data |
| wb_rdat | output | 8 | Read data |
| wb_we | input | 1 | Write enable |
| wb_stb | input | 1 | Strobe |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_ack | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt request |
| prescale_o | output | 16 | Clock divider value |
| core_en_o | output | 1 | Core enable |
| cmd_start_o | output | 1 | Start pulse |
| cmd_stop_o | output | 1 | Stop pulse |
| cmd_read_o | output | 1 | Read byte pulse |
| cmd_write_o | output | 1 | Write byte pulse |
| cmd_nack_o | output | 1 | Acknowledge level to send when receiving (1 = NACK) |
| tx_data_o | output | 8 | Byte to transmit |
| rx_data_i | input | 8 | Byte received by the sequencer |
| ctl_done_i | input | 1 | Byte transfer finished |
| ctl_rxack_i | input | 1 | Acknowledge seen from the slave (1 = none) |
| ctl_busy_i | input | 1 | Bus busy |
| ctl_al_i | input | 1 | Arbitration lost |

## Verification
The assertions assume a host that follows the classic handshake. Strobe is raised only with a valid cycle and is dropped right after the acknowledge, so no access is issued back to back without a gap. The assertions also assume the sequencer gives done and arbitration lost as short pulses. The bench drives every access through one task that raises strobe on a falling edge and drops it after the acknowledge cycle. A stand-in sequencer pulses done or arbitration lost for one cycle at a time. One of those pulses is deliberately aligned with an interrupt-acknowledge write to exercise the same-edge priority.

// File: rtl/i2c_regif.sv
module i2c_regif #(
  parameter logic ARST_ACTIVE = 1'b0,
  parameter int   AW          = 3,
  parameter int   DW          = 8
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          arst,
  input  logic [AW-1:0] wb_adr,
  input  logic [DW-1:0] wb_wdat,
  output logic [DW-1:0] wb_rdat,
  input  logic          wb_we,
  input  logic          wb_stb,
  input  logic          wb_cyc,
  output logic          wb_ack,
  output logic          irq_o,
  output logic [2*DW-1:0] prescale_o,
  output logic          core_en_o,
  output logic          cmd_start_o,
  output logic          cmd_stop_o,
  output logic          cmd_read_o,
  output logic          cmd_write_o,
  output logic          cmd_nack_o,
  output logic [DW-1:0] tx_data_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic          ctl_done_i,
  input  logic          ctl_rxack_i,
  input  logic          ctl_busy_i,
  input  logic          ctl_al_i
);
  localparam logic [AW-1:0] A_PLO = AW'(0);
  localparam logic [AW-1:0] A_PHI = AW'(1);
  localparam logic [AW-1:0] A_CTL = AW'(2);
  localparam logic [AW-1:0] A_DAT = AW'(3);
  localparam logic [AW-1:0] A_CMD = AW'(4);

  logic          arst_int;
  logic          acc, wr, cmd_ok;
  logic          ien_q, pend_q, al_q, rxack_q, if_q;
  logic [DW-1:0] rx_q, stat, rmux;

  assign arst_int = (arst == ARST_ACTIVE);
  assign acc      = wb_cyc & wb_stb & ~wb_ack;
  assign wr       = acc & wb_we;
  assign cmd_ok   = wr & (wb_adr == A_CMD) & core_en_o;

  assign stat = {rxack_q, ctl_busy_i, al_q, 3'b000, pend_q, if_q};

  always_comb begin
    case (wb_adr)
      A_PLO:   rmux = prescale_o[DW-1:0];
      A_PHI:   rmux = prescale_o[2*DW-1:DW];
      A_CTL:   rmux = {core_en_o, ien_q, {(DW-2){1'b0}}};
      A_DAT:   rmux = rx_q;
      A_CMD:   rmux = stat;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or posedge arst_int) begin
    if (arst_int) begin
      wb_ack  <= 1'b0;
      wb_rdat <= '0;
    end else if (srst) begin
      wb_ack  <= 1'b0;
      wb_rdat <= '0;
    end else begin
      wb_ack <= acc;
      if (acc) wb_rdat <= rmux;
    end
  end

  always_ff @(posedge clk or posedge arst_int) begin
    if (arst_int) begin
      prescale_o <= '1;
      core_en_o  <= 1'b0;
      ien_q      <= 1'b0;
      tx_data_o  <= '0;
    end else if (srst) begin
      prescale_o <= '1;
      core_en_o  <= 1'b0;
      ien_q      <= 1'b0;
      tx_data_o  <= '0;
    end else if (wr) begin
      case (wb_adr)
        A_PLO:   prescale_o[DW-1:0]    <= wb_wdat;
        A_PHI:   prescale_o[2*DW-1:DW] <= wb_wdat;
        A_CTL:   {core_en_o, ien_q}    <= wb_wdat[7:6];
        A_DAT:   tx_data_o             <= wb_wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst_int) begin
    if (arst_int) begin
      {cmd_start_o, cmd_stop_o, cmd_read_o, cmd_write_o} <= '0;
      cmd_nack_o <= 1'b0;
      pend_q     <= 1'b0;
      al_q       <= 1'b0;
    end else if (srst) begin
      {cmd_start_o, cmd_stop_o, cmd_read_o, cmd_write_o} <= '0;
      cmd_nack_o <= 1'b0;
      pend_q     <= 1'b0;
      al_q       <= 1'b0;
    end else begin
      {cmd_start_o, cmd_stop_o, cmd_read_o, cmd_write_o} <= '0;
      if (ctl_done_i | ctl_al_i | ~core_en_o) pend_q <= 1'b0;
      if (ctl_al_i) al_q <= 1'b1;
      else if (cmd_ok & wb_wdat[7]) al_q <= 1'b0;
      if (cmd_ok) begin
        {cmd_start_o, cmd_stop_o, cmd_read_o, cmd_write_o} <= wb_wdat[7:4];
        cmd_nack_o <= wb_wdat[3];
        if (wb_wdat[5] | wb_wdat[4]) pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge arst_int) begin
    if (arst_int) begin
      rx_q    <= '0;
      rxack_q <= 1'b0;
      if_q    <= 1'b0;
      irq_o   <= 1'b0;
    end else if (srst) begin
      rx_q    <= '0;
      rxack_q <= 1'b0;
      if_q    <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (ctl_done_i) begin
        rx_q    <= rx_data_i;
        rxack_q <= ctl_rxack_i;
      end
      if (ctl_done_i | ctl_al_i) if_q <= 1'b1;
      else if (wr & (wb_adr == A_CMD) & wb_wdat[0]) if_q <= 1'b0;
      irq_o <= if_q & ien_q;
    end
  end
endmodule

module i2c_regif_chk (
  input logic clk,
  input logic rst_any,
  input logic wb_cyc,
  input logic wb_stb,
  input logic wb_ack,
  input logic cmd_start_o,
  input logic cmd_stop_o,
  input logic cmd_read_o,
  input logic cmd_write_o,
  input logic core_en_o,
  input logic ctl_done_i,
  input logic ctl_al_i,
  input logic if_q,
  input logic ien_q,
  input logic pend_q,
  input logic irq_o
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst_any)
    wb_ack |=> !wb_ack); // R2
  AST_ACK_NEEDS_STB: assert property (@(posedge clk) disable iff (rst_any)
    wb_ack |-> $past(wb_cyc && wb_stb)); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst_any)
    cmd_start_o |=> !cmd_start_o); // R4
  AST_RW_PULSE: assert property (@(posedge clk) disable iff (rst_any)
    (cmd_read_o || cmd_write_o) |=> !(cmd_read_o || cmd_write_o)); // R4
  AST_CMD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst_any)
    (cmd_start_o || cmd_stop_o || cmd_read_o || cmd_write_o) |-> $past(core_en_o)); // R5
  AST_TIP_CLEAR: assert property (@(posedge clk) disable iff (rst_any)
    (ctl_done_i || ctl_al_i) |=> !pend_q || $past(core_en_o)); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst_any)
    (ctl_done_i || ctl_al_i) |=> if_q); // R7
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst_any)
    irq_o == $past(if_q && ien_q)); // R8
  AST_EN_CANCEL: assert property (@(posedge clk) disable iff (rst_any)
    !core_en_o |=> !pend_q); // R10
endmodule

bind i2c_regif i2c_regif_chk u_chk (
  .clk(clk), .rst_any(arst_int || srst),
  .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_ack(wb_ack),
  .cmd_start_o(cmd_start_o), .cmd_stop_o(cmd_stop_o),
  .cmd_read_o(cmd_read_o), .cmd_write_o(cmd_write_o),
  .core_en_o(core_en_o), .ctl_done_i(ctl_done_i), .ctl_al_i(ctl_al_i),
  .if_q(if_q), .ien_q(ien_q), .pend_q(pend_q), .irq_o(irq_o)
);

// File: tb/i2c_regif_tb.sv
`timescale 1ns/1ps
module i2c_regif_tb;
  logic clk = 1'b0;
  logic srst = 1'b0, arst = 1'b0;
  logic [2:0] adr = '0;
  logic [7:0] wdat = '0, rdat;
  logic we = 1'b0, stb = 1'b0, cyc = 1'b0, ack, irq;
  logic [15:0] presc;
  logic en, c_sta, c_sto, c_rd, c_wr, c_nack;
  logic [7:0] txd, rxd = '0;
  logic done = 1'b0, rxack = 1'b0, busy = 1'b0, al = 1'b0;

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;
  logic [7:0] got;
  logic [3:0] cap;

  always #5 clk = ~clk;

  i2c_regif u_dut (
    .clk(clk), .srst(srst), .arst(arst), .wb_adr(adr), .wb_wdat(wdat),
    .wb_rdat(rdat), .wb_we(we), .wb_stb(stb), .wb_cyc(cyc), .wb_ack(ack),
    .irq_o(irq), .prescale_o(presc), .core_en_o(en),
    .cmd_start_o(c_sta), .cmd_stop_o(c_sto), .cmd_read_o(c_rd),
    .cmd_write_o(c_wr), .cmd_nack_o(c_nack), .tx_data_o(txd),
    .rx_data_i(rxd), .ctl_done_i(done), .ctl_rxack_i(rxack),
    .ctl_busy_i(busy), .ctl_al_i(al)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(logic w, logic [2:0] a, logic [7:0] d, logic with_done = 1'b0);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    if (with_done) done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R2 ack in second cycle", {15'd0, ack}, 16'd1);
    got = rdat;
    cap = {c_sta, c_sto, c_rd, c_wr};
    @(posedge clk);
    #1 cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R2 ack single cycle", {15'd0, ack}, 16'd0);
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
    bus(1'b0, a, 8'h00);
    chk(req, {8'd0, got}, {8'd0, exp});
  endtask

  task automatic ctl_pulse(logic is_al);
    @(negedge clk);
    if (is_al) al = 1'b1; else done = 1'b1;
    @(negedge clk);
    al = 1'b0; done = 1'b0;
  endtask

  // {we, adr, wdat, expected read}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 8'hFF}, {1'b0, 3'd1, 8'h00, 8'hFF},
    {1'b0, 3'd2, 8'h00, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h3F, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h3F}, {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'hFF, 8'h00}, {1'b0, 3'd2, 8'h00, 8'hC0},
    {1'b1, 3'd3, 8'hA2, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h5B, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h5B}
  };

  initial begin
    repeat (3) @(negedge clk);
    arst = 1'b1;
    @(negedge clk);
    chk("R1 reset divider", presc, 16'hFFFF);
    chk("R1 reset outputs", {11'd0, irq, ack, en, c_nack, 1'b0}, 16'd0);
    chk("R1 reset tx", {8'd0, txd}, 16'd0);

    foreach (VEC[i]) begin
      bus(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      if (!VEC[i][19]) chk("R1 R3 register read", {8'd0, got}, {8'd0, VEC[i][7:0]});
    end
    chk("R3 divider output", presc, 16'h5B3F);
    chk("R3 tx output", {8'd0, txd}, 16'h00A2);
    chk("R3 enable output", {15'd0, en}, 16'd1);

    bus(1'b1, 3'd4, 8'h90);
    chk("R4 start+write pulses", {12'd0, cap}, 16'h0009);
    chk("R4 pulses gone", {12'd0, c_sta, c_sto, c_rd, c_wr}, 16'd0);
    rd(3'd4, 8'h02, "R6 tip set");

    rxd = 8'h5A; rxack = 1'b0;
    ctl_pulse(1'b0);
    @(negedge clk);
    chk("R8 irq raised", {15'd0, irq}, 16'd1);
    rd(3'd4, 8'h01, "R6 R7 tip clear flag set");
    rd(3'd3, 8'h5A, "R9 rx latched");

    bus(1'b1, 3'd2, 8'h80);
    chk("R8 irq masked", {15'd0, irq}, 16'd0);
    bus(1'b1, 3'd4, 8'h01);
    rd(3'd4, 8'h00, "R7 iack clears");

    rxd = 8'hC3; rxack = 1'b1;
    bus(1'b1, 3'd4, 8'h01, 1'b1);
    rd(3'd4, 8'h81, "R7 set beats iack, R9 rxack");
    rd(3'd3, 8'hC3, "R9 rx second byte");
    bus(1'b1, 3'd4, 8'h01);
    rd(3'd4, 8'h80, "R7 iack");

    busy = 1'b1;
    ctl_pulse(1'b1);
    rd(3'd4, 8'hE1, "R9 al busy status");
    bus(1'b1, 3'd4, 8'h80);
    chk("R4 start only", {12'd0, cap}, 16'h0008);
    rd(3'd4, 8'hC1, "R9 start clears al");
    busy = 1'b0;
    bus(1'b1, 3'd4, 8'h01);

    bus(1'b1, 3'd2, 8'h00);
    bus(1'b1, 3'd4, 8'h10);
    chk("R5 no pulse when disabled", {12'd0, cap}, 16'd0);
    rd(3'd4, 8'h80, "R5 no tip when disabled");

    bus(1'b1, 3'd2, 8'h80);
    bus(1'b1, 3'd4, 8'h20);
    chk("R4 read pulse", {12'd0, cap}, 16'h0002);
    rd(3'd4, 8'h82, "R6 tip on read");
    bus(1'b1, 3'd2, 8'h00);
    rd(3'd4, 8'h80, "R10 disable cancels tip");

    bus(1'b1, 3'd2, 8'h80);
    bus(1'b1, 3'd4, 8'h08);
    chk("R4 nack level", {15'd0, c_nack}, 16'd1);
    bus(1'b1, 3'd4, 8'h00);
    chk("R4 ack level", {15'd0, c_nack}, 16'd0);

    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    chk("R11 sync reset divider", presc, 16'hFFFF);
    chk("R11 sync reset enable", {15'd0, en}, 16'd0);
    rd(3'd4, 8'h00, "R11 sync reset status");

    bus(1'b1, 3'd0, 8'h12);
    chk("R3 divider low write", presc, 16'hFF12);
    @(negedge clk);
    #1 arst = 1'b0;
    #1 chk("R11 async reset no clock", presc, 16'hFFFF);
    @(negedge clk); arst = 1'b1;
    @(negedge clk);
    chk("R11 after async release", presc, 16'hFFFF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule